// File: doc/BRIEF.md
# Intrusion Status Latch

This block captures a chassis-intrusion event into a status bit. It also requests a system-management interrupt when intrusion reporting is enabled. The intrusion input is active low and asynchronous, so it is synchronized before any detection. The status bit sets on each inactive-to-active transition of the synchronized input. Only an RTC-domain reset or a software write of 1 returns it to 0.

The clearing rule depends on the level of the input. A clear written while the input is still active is refused: the bit stays at 1, an interrupt is requested again, and the clear is held as pending. When the input later goes inactive, the bit drops by itself. A clear written while the input is inactive takes effect at once. The value read back stays at 1 for a recovery window, measured in clock cycles, before it shows 0.

Top module: `intrusion_status_latch`

## Requirements
- R1: While reset is asserted and after it is released with the input inactive, `status_o` and `smi_o` are both 0.
- R2: A high-to-low transition on `intr_n_i` sets `status_o` on the third rising clock edge after the change. Two of those edges are synchronizer stages and one is the status register.
- R3: When `irq_sel_i` is not 2'b00, each set event produces a `smi_o` pulse lasting exactly one clock cycle. The pulse appears in the same cycle as the status bit.
- R4: With `irq_sel_i` equal to 2'b00, no `smi_o` pulse is produced for any event. The status bit still sets.
- R5: A strobe on `clr_we_i` with `clr_data_i` = 1, while the synchronized input is inactive and the bit is set, clears the internal bit. `status_o` then reads 1 for REC_CYCLES further cycles after the clearing edge, and 0 from then on.
- R6: A strobe with `clr_data_i` = 0 has no effect. The bit stays set and no recovery window starts.
- R7: A clear written while the synchronized input is active is refused. `status_o` stays 1, and if `irq_sel_i` is not 2'b00, `smi_o` pulses on the edge that takes the write.
- R8: After a refused clear, the bit drops to 0 on the third edge after `intr_n_i` returns high. No recovery window applies, so `status_o` reads 0 at once.
- R9: Without a pending clear, the input returning inactive does not clear the bit.
- R10: A clear strobe taken on the same edge as a set event counts as refused. The bit stays 1, a single `smi_o` pulse is produced, and the clear is held pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | RTC-domain reset, asynchronous, active low |
| intr_n_i | input | 1 | Intrusion input, asynchronous, active low |
| irq_sel_i | input | 2 | Interrupt select; 2'b00 suppresses interrupts |
| clr_we_i | input | 1 | Write strobe for the status bit position |
| clr_data_i | input | 1 | Data written; 1 clears, 0 has no effect |
| status_o | output | 1 | Status read-back value |
| smi_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The set detection and a software clear can act on the same clock edge. The bench provokes this by raising the intrusion input and timing the clear strobe so that it lands on the third edge after the change, which is when the synchronized rise registers. The result counts as correct only if the bit stays 1, exactly one interrupt pulse appears, and the bit later drops three edges after the input is released. That last point shows the clear was held as pending and not lost.

// File: rtl/isl_pkg.sv
package isl_pkg;

  typedef enum logic [1:0] {
    SEL_OFF   = 2'b00,
    SEL_SMI_A = 2'b01,
    SEL_SMI_B = 2'b10,
    SEL_SMI_C = 2'b11
  } irq_sel_e;

  function automatic logic sel_enables(input logic [1:0] sel);
    irq_sel_e s;
    s = irq_sel_e'(sel);
    case (s)
      SEL_OFF: sel_enables = 1'b0;
      default: sel_enables = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/isl_rst_sync.sv
module isl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[LAST];
endmodule

// File: rtl/isl_sync.sv
module isl_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/isl_recovery.sv
module isl_recovery #(
  parameter int REC_CYCLES = 13000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(REC_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(REC_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          busy;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = load_i | busy;
    if (load_i) cnt_d = LOAD_VAL;
    else        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = busy;

  assert_window_counts_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load_i) |=> (cnt_q == CW'($past(cnt_q) - CW'(1))));

  assert_window_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);
endmodule

// File: rtl/isl_core.sv
module isl_core
  import isl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic [1:0] sel_i,
  input  logic       clr_we_i,
  input  logic       clr_data_i,
  output logic       status_o,
  output logic       smi_o,
  output logic       rec_load_o
);
  logic active_d_q;
  logic status_q, status_d;
  logic pending_q, pending_d;
  logic smi_q, smi_d;
  logic rise, fall, clr_hit, refused, accept, irq_en;

  always_comb begin
    irq_en    = sel_enables(sel_i);
    rise      = active_i & ~active_d_q;
    fall      = ~active_i & active_d_q;
    clr_hit   = clr_we_i & clr_data_i;
    refused   = clr_hit & active_i;
    accept    = clr_hit & ~active_i;

    status_d  = status_q;
    if (rise)                  status_d = 1'b1;
    else if (accept)           status_d = 1'b0;
    else if (pending_q & fall) status_d = 1'b0;

    pending_d = pending_q;
    if (refused)             pending_d = 1'b1;
    else if (fall | accept)  pending_d = 1'b0;

    smi_d      = irq_en & (rise | refused);
    rec_load_o = accept & status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_d_q <= 1'b0;
      status_q   <= 1'b0;
      pending_q  <= 1'b0;
      smi_q      <= 1'b0;
    end else begin
      active_d_q <= active_i;
      status_q   <= status_d;
      pending_q  <= pending_d;
      smi_q      <= smi_d;
    end
  end

  assign status_o = status_q;
  assign smi_o    = smi_q;

  assert_set_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !active_d_q) |=> status_q);

  assert_pulse_on_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !active_d_q && sel_i != 2'b00) |=> smi_q);

  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'b00) |=> !smi_q);

  assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_data_i && !active_i) |=> !status_q);

  assert_refuse_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_data_i && active_i) |=> (status_q && pending_q));

  assert_pending_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !active_i && active_d_q) |=> !status_q);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !pending_q && !(clr_we_i && clr_data_i)) |=> status_q);

  assert_pending_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> status_q);
endmodule

// File: rtl/intrusion_status_latch.sv
module intrusion_status_latch #(
  parameter int REC_CYCLES  = 13000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       intr_n_i,
  input  logic [1:0] irq_sel_i,
  input  logic       clr_we_i,
  input  logic       clr_data_i,
  output logic       status_o,
  output logic       smi_o
);
  logic rst_n_s;
  logic intr_n_s;
  logic active;
  logic status_q;
  logic rec_load;
  logic rec_busy;

  isl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  isl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_in_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (intr_n_i),
    .sync_o  (intr_n_s)
  );

  assign active = ~intr_n_s;

  isl_core u_core (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .active_i   (active),
    .sel_i      (irq_sel_i),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .status_o   (status_q),
    .smi_o      (smi_o),
    .rec_load_o (rec_load)
  );

  isl_recovery #(.REC_CYCLES(REC_CYCLES)) u_recovery (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (rec_load),
    .busy_o (rec_busy)
  );

  assign status_o = status_q | rec_busy;

  assert_readback_lags_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    rec_load |=> (status_o && !status_q));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_s |-> (!status_q && !smi_o));
endmodule

// File: tb/intrusion_status_latch_tb.sv
`timescale 1ns/1ps
module intrusion_status_latch_tb;
  localparam int REC = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       intr_n;
  logic [1:0] sel;
  logic       clr_we;
  logic       clr_data;
  logic       status;
  logic       smi;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  intrusion_status_latch #(.REC_CYCLES(REC)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .intr_n_i   (intr_n),
    .irq_sel_i  (sel),
    .clr_we_i   (clr_we),
    .clr_data_i (clr_data),
    .status_o   (status),
    .smi_o      (smi)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_bit(input logic d);
    clr_we = 1'b1; clr_data = d;
    step(1);
    clr_we = 1'b0; clr_data = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; intr_n = 1'b1; sel = 2'b01; clr_we = 1'b0; clr_data = 1'b0;
    step(3);
    check("R1 status in reset", status, 1'b0);
    check("R1 smi in reset", smi, 1'b0);
    rst_n = 1'b1;
    step(6);
    check("R1 status after reset", status, 1'b0);
    check("R1 smi after reset", smi, 1'b0);
  endtask

  task automatic t_set_pulse;
    sel = 2'b01;
    intr_n = 1'b0;
    step(2);
    check("R2 status before sync", status, 1'b0);
    step(1);
    check("R2 status set", status, 1'b1);
    check("R3 smi pulse", smi, 1'b1);
    step(1);
    check("R3 smi one cycle", smi, 1'b0);
  endtask

  task automatic t_sticky;
    intr_n = 1'b1;
    step(10);
    check("R9 sticky after release", status, 1'b1);
  endtask

  task automatic t_write_zero;
    write_bit(1'b0);
    check("R6 write zero no effect", status, 1'b1);
    step(REC + 2);
    check("R6 still set later", status, 1'b1);
    check("R6 no pulse", smi, 1'b0);
  endtask

  task automatic t_clear_ok;
    write_bit(1'b1);
    check("R5 readback held", status, 1'b1);
    check("R5 no pulse on accept", smi, 1'b0);
    step(REC - 1);
    check("R5 readback held end", status, 1'b1);
    step(1);
    check("R5 readback zero", status, 1'b0);
  endtask

  task automatic t_sel_off;
    sel = 2'b00;
    intr_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step(1);
      check("R4 no pulse when off", smi, 1'b0);
    end
    check("R4 status sets when off", status, 1'b1);
    write_bit(1'b1);
    check("R7 refused while active", status, 1'b1);
    check("R4 refused no pulse", smi, 1'b0);
    intr_n = 1'b1;
    step(2);
    check("R8 still set before sync", status, 1'b1);
    step(1);
    check("R8 drops on release", status, 1'b0);
  endtask

  task automatic t_refused_pulse;
    sel = 2'b10;
    intr_n = 1'b0;
    step(4);
    check("R3 set with sel 10", status, 1'b1);
    write_bit(1'b1);
    check("R7 refused keeps", status, 1'b1);
    check("R7 refused pulse", smi, 1'b1);
    step(1);
    check("R7 pulse ends", smi, 1'b0);
    intr_n = 1'b1;
    step(2);
    check("R8 held until sync", status, 1'b1);
    step(1);
    check("R8 immediate zero", status, 1'b0);
    step(3);
    check("R8 no recovery window", status, 1'b0);
  endtask

  task automatic t_same_edge;
    sel = 2'b01;
    intr_n = 1'b0;
    step(2);
    write_bit(1'b1);
    check("R10 status kept", status, 1'b1);
    check("R10 single pulse", smi, 1'b1);
    step(1);
    check("R10 pulse ends", smi, 1'b0);
    intr_n = 1'b1;
    step(2);
    check("R10 pending held", status, 1'b1);
    step(1);
    check("R10 pending drop", status, 1'b0);
  endtask

  initial begin
    t_reset();
    t_set_pulse();
    t_sticky();
    t_write_zero();
    t_clear_ok();
    step(4);
    t_sel_off();
    step(4);
    t_refused_pulse();
    step(4);
    t_same_edge();
    step(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule